// File: doc/BRIEF.md
# Banked Index Address Unit

This unit turns index-relative operand references of a 16-bit CPU core into 20-bit physical data addresses. Each of the two index registers has its own 4-bit bank register. For an index-relative reference, the unit adds a sign-extended 8-bit displacement to the index value and keeps the low 16 bits of the sum. It then places the selected bank value above that sum. References that are not based on an index register get bank zero, so they stay in the lowest 64 KB of the 1 MB space.

The unit also executes two pointer commands, step-up and step-down. These treat a bank register and its index value as one 20-bit pointer. The command operand is at page FF00h plus an 8-bit offset, and the unit drives that address while the command runs. The core supplies the current index value. The unit returns the stepped index value for the core to write back. When the 16-bit index wraps, the unit carries into or borrows from the paired bank register.

All outputs are registered and appear one clock after the inputs are presented. Instruction decode and the memory bus are not part of this unit.

Top module: `sei_addr_unit`

## Requirements
- R1: After reset both bank registers are zero, `phys_addr` is 0 and `idx_next_vld` is 0.
- R2: With no pointer command, `addr_sel` = 1 (index 0) or 2 (index 1) gives `phys_addr` = {bank of that index, (`base_val` + sign-extended `disp`) mod 2^16} one clock later. The bank value used is the one held before that clock edge.
- R3: With no pointer command, `addr_sel` = 0 or 3 (direct) gives `phys_addr` = {4'h0, `base_val`} one clock later, ignoring `disp` and both banks.
- R4: `bank_wr_en[i]` loads `bank_wr_data` into bank i at the clock edge. The other bank keeps its value.
- R5: `ptr_cmd` = 1 (step-up) drives `idx_next` = (`base_val` + 1) mod 2^16 with `idx_next_vld` = 1 one clock later. When `base_val` is FFFFh, the bank chosen by `ptr_sel` increments modulo 16. `idx_next_vld` is 0 in any cycle that follows no step command.
- R6: `ptr_cmd` = 2 (step-down) drives `idx_next` = (`base_val` - 1) mod 2^16 with `idx_next_vld` = 1 one clock later. When `base_val` is 0000h, the bank chosen by `ptr_sel` decrements modulo 16.
- R7: A step command that does not wrap the index leaves both banks unchanged. A step command also leaves the bank it does not select unchanged.
- R8: During a step command, `phys_addr` is {4'h0, 8'hFF, `ptr_ofs`} one clock later, whatever `addr_sel` is. `ptr_cmd` = 3 acts as no command.
- R9: If a bank write and a carry or borrow hit the same bank in one cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Address source: 0/3 direct, 1 index 0, 2 index 1 |
| base_val | input | 16 | Index value or direct address; current index for step commands |
| disp | input | 8 | Signed displacement |
| bank_wr_en | input | 2 | Per-bank write strobe |
| bank_wr_data | input | 4 | Bank write data |
| ptr_cmd | input | 2 | 0 none, 1 step-up, 2 step-down, 3 none |
| ptr_sel | input | 1 | Bank/index pair targeted by a step command |
| ptr_ofs | input | 8 | Offset of the step operand in page FF00h |
| phys_addr | output | 20 | Registered physical address |
| idx_next | output | 16 | Stepped index value for write-back |
| idx_next_vld | output | 1 | idx_next valid |

## Verification
The bench sweeps every bank value on both banks against displacements at and around the sign boundary, with index values near 0000h, 8000h and FFFFh. A design that zero-extends the displacement, or that carries the displacement sum into the bank, gives wrong upper or lower address bits. Step commands run at FFFFh and 0000h with bank values 0 and 15. These cases expose a missing carry or borrow, a missing modulo-16 wrap, and a carry that lands on the wrong bank. The bench also issues a bank write and a carry to the same bank in one cycle, and a design that lets the carry win leaves the wrong bank value in later addresses. Direct references are issued with nonzero banks, so a design that leaks a bank value into them shows up.

// File: rtl/sei_pkg.sv
package sei_pkg;

    typedef enum logic [1:0] {
        PTR_NONE = 2'd0,
        PTR_INC  = 2'd1,
        PTR_DEC  = 2'd2,
        PTR_RSV  = 2'd3
    } ptr_cmd_e;

    function automatic logic is_step(input logic [1:0] cmd);
        return (cmd == PTR_INC) || (cmd == PTR_DEC);
    endfunction

endpackage

// File: rtl/sei_ea_adder.sv
module sei_ea_adder #(
    parameter int IDX_W  = 16,
    parameter int DISP_W = 8
) (
    input  logic [IDX_W-1:0]  base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [IDX_W-1:0]  ea
);
    localparam int EXT_W = IDX_W - DISP_W;

    logic [IDX_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base_val + disp_ext;
    end
endmodule

// File: rtl/sei_ptr_step.sv
module sei_ptr_step #(
    parameter int IDX_W = 16
) (
    input  logic [1:0]       cmd,
    input  logic [IDX_W-1:0] val,
    output logic [IDX_W-1:0] val_next,
    output logic             wrap_up,
    output logic             wrap_dn
);
    import sei_pkg::*;

    localparam logic [IDX_W-1:0] ALL_ONES = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

    always_comb begin
        val_next = val;
        wrap_up  = 1'b0;
        wrap_dn  = 1'b0;
        if (cmd == PTR_INC) begin
            val_next = val + ONE;
            wrap_up  = (val == ALL_ONES);
        end else if (cmd == PTR_DEC) begin
            val_next = val - ONE;
            wrap_dn  = (val == '0);
        end
    end
endmodule

// File: rtl/sei_bank_next.sv
module sei_bank_next #(
    parameter int BANK_W  = 4,
    parameter int NUM_IDX = 2,
    parameter int PSEL_W  = 1
) (
    input  logic [NUM_IDX-1:0][BANK_W-1:0] bank_q,
    input  logic [NUM_IDX-1:0]             wr_en,
    input  logic [BANK_W-1:0]              wr_data,
    input  logic                           step_act,
    input  logic [PSEL_W-1:0]              step_sel,
    input  logic                           wrap_up,
    input  logic                           wrap_dn,
    output logic [NUM_IDX-1:0][BANK_W-1:0] bank_d
);
    localparam logic [BANK_W-1:0] B_ONE = BANK_W'(1);

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_bank
        logic hit;
        always_comb begin
            hit = step_act && (step_sel == PSEL_W'(k));
            if (wr_en[k])
                bank_d[k] = wr_data;
            else if (hit && wrap_up)
                bank_d[k] = bank_q[k] + B_ONE;
            else if (hit && wrap_dn)
                bank_d[k] = bank_q[k] - B_ONE;
            else
                bank_d[k] = bank_q[k];
        end
    end
endmodule

// File: rtl/sei_addr_unit.sv
module sei_addr_unit #(
    parameter int IDX_W   = 16,
    parameter int BANK_W  = 4,
    parameter int DISP_W  = 8,
    parameter int NUM_IDX = 2,
    parameter logic [IDX_W-DISP_W-1:0] PTR_PAGE = 8'hFF,
    localparam int ADDR_W = IDX_W + BANK_W,
    localparam int SEL_W  = $clog2(NUM_IDX + 2),
    localparam int PSEL_W = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     addr_sel,
    input  logic [IDX_W-1:0]     base_val,
    input  logic [DISP_W-1:0]    disp,
    input  logic [NUM_IDX-1:0]   bank_wr_en,
    input  logic [BANK_W-1:0]    bank_wr_data,
    input  logic [1:0]           ptr_cmd,
    input  logic [PSEL_W-1:0]    ptr_sel,
    input  logic [DISP_W-1:0]    ptr_ofs,
    output logic [ADDR_W-1:0]    phys_addr,
    output logic [IDX_W-1:0]     idx_next,
    output logic                 idx_next_vld
);
    import sei_pkg::*;

    typedef struct packed {
        logic [NUM_IDX-1:0][BANK_W-1:0] bank;
        logic [ADDR_W-1:0]              addr;
        logic [IDX_W-1:0]               idx;
        logic                           vld;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]               ea;
    logic [IDX_W-1:0]               step_val;
    logic                           wrap_up, wrap_dn;
    logic                           step_act;
    logic [NUM_IDX-1:0][BANK_W-1:0] bank_nx;
    logic [NUM_IDX-1:0][BANK_W-1:0] bank_view;

    assign step_act  = is_step(ptr_cmd);
    assign bank_view = st_q.bank;

    sei_ea_adder #(.IDX_W(IDX_W), .DISP_W(DISP_W)) u_ea (
        .base_val (base_val),
        .disp     (disp),
        .ea       (ea)
    );

    sei_ptr_step #(.IDX_W(IDX_W)) u_step (
        .cmd      (ptr_cmd),
        .val      (base_val),
        .val_next (step_val),
        .wrap_up  (wrap_up),
        .wrap_dn  (wrap_dn)
    );

    sei_bank_next #(.BANK_W(BANK_W), .NUM_IDX(NUM_IDX), .PSEL_W(PSEL_W)) u_bank (
        .bank_q   (st_q.bank),
        .wr_en    (bank_wr_en),
        .wr_data  (bank_wr_data),
        .step_act (step_act),
        .step_sel (ptr_sel),
        .wrap_up  (wrap_up),
        .wrap_dn  (wrap_dn),
        .bank_d   (bank_nx)
    );

    always_comb begin
        logic              idx_mode;
        logic [BANK_W-1:0] bank_sel;

        st_d     = st_q;
        idx_mode = 1'b0;
        bank_sel = '0;
        for (int k = 0; k < NUM_IDX; k++) begin
            if (addr_sel == SEL_W'(k + 1)) begin
                idx_mode = 1'b1;
                bank_sel = st_q.bank[k];
            end
        end

        if (step_act)
            st_d.addr = {{BANK_W{1'b0}}, PTR_PAGE, ptr_ofs};
        else if (idx_mode)
            st_d.addr = {bank_sel, ea};
        else
            st_d.addr = {{BANK_W{1'b0}}, base_val};

        st_d.vld  = step_act;
        st_d.idx  = step_act ? step_val : st_q.idx;
        st_d.bank = bank_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign phys_addr    = st_q.addr;
    assign idx_next     = st_q.idx;
    assign idx_next_vld = st_q.vld;

endmodule

// File: rtl/sei_addr_unit_chk.sv
module sei_addr_unit_chk #(
    parameter int IDX_W   = 16,
    parameter int BANK_W  = 4,
    parameter int DISP_W  = 8,
    parameter int NUM_IDX = 2,
    parameter int ADDR_W  = 20,
    parameter int SEL_W   = 2,
    parameter int PSEL_W  = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [SEL_W-1:0]               addr_sel,
    input logic [IDX_W-1:0]               base_val,
    input logic [DISP_W-1:0]              disp,
    input logic [NUM_IDX-1:0]             bank_wr_en,
    input logic [BANK_W-1:0]              bank_wr_data,
    input logic [1:0]                     ptr_cmd,
    input logic [PSEL_W-1:0]              ptr_sel,
    input logic [DISP_W-1:0]              ptr_ofs,
    input logic [ADDR_W-1:0]              phys_addr,
    input logic [IDX_W-1:0]               idx_next,
    input logic                           idx_next_vld,
    input logic [NUM_IDX-1:0][BANK_W-1:0] bank_view
);
    localparam int EXT_W = IDX_W - DISP_W;

    logic step;
    assign step = (ptr_cmd == 2'd1) || (ptr_cmd == 2'd2);

    assert_idle_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !idx_next_vld);

    assert_step_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> idx_next_vld);

    assert_inc_val_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_cmd == 2'd1) |=> idx_next == IDX_W'($past(base_val) + IDX_W'(1)));

    assert_dec_val_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_cmd == 2'd2) |=> idx_next == IDX_W'($past(base_val) - IDX_W'(1)));

    assert_page_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> phys_addr[IDX_W-1:DISP_W] == {EXT_W{1'b1}} &&
                 phys_addr[ADDR_W-1:IDX_W] == '0 &&
                 phys_addr[DISP_W-1:0] == $past(ptr_ofs));

    assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && (addr_sel == SEL_W'(0) || addr_sel == SEL_W'(3)))
            |=> phys_addr == {{BANK_W{1'b0}}, $past(base_val)});

    assert_index_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && addr_sel == SEL_W'(1))
            |=> phys_addr[IDX_W-1:0] ==
                IDX_W'($past(base_val) + {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)}));

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_bank_chk
        assert_write_R4_R9: assert property (@(posedge clk) disable iff (!rst_n)
            bank_wr_en[k] |=> bank_view[k] == $past(bank_wr_data));

        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!bank_wr_en[k] && !step) |=> $stable(bank_view[k]));
    end

endmodule

bind sei_addr_unit sei_addr_unit_chk #(
    .IDX_W(IDX_W), .BANK_W(BANK_W), .DISP_W(DISP_W), .NUM_IDX(NUM_IDX),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .PSEL_W(PSEL_W)
) u_chk (.*);

// File: tb/sei_addr_unit_tb.sv
module sei_addr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_sel = '0;
    logic [15:0] base_val = '0;
    logic [7:0]  disp = '0;
    logic [1:0]  bank_wr_en = '0;
    logic [3:0]  bank_wr_data = '0;
    logic [1:0]  ptr_cmd = '0;
    logic        ptr_sel = 1'b0;
    logic [7:0]  ptr_ofs = '0;
    logic [19:0] phys_addr;
    logic [15:0] idx_next;
    logic        idx_next_vld;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] bk [2];

    always #10 clk = ~clk;

    sei_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .base_val(base_val),
        .disp(disp), .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data),
        .ptr_cmd(ptr_cmd), .ptr_sel(ptr_sel), .ptr_ofs(ptr_ofs),
        .phys_addr(phys_addr), .idx_next(idx_next), .idx_next_vld(idx_next_vld)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] sel, input logic [15:0] base, input logic [7:0] d,
                        input logic [1:0] we, input logic [3:0] wd, input logic [1:0] cmd,
                        input logic ps, input logic [7:0] ofs, input string tag);
        logic [19:0] ea;
        logic [15:0] sum;
        logic [15:0] en;
        logic        ptr;
        ptr = (cmd == 2'd1) || (cmd == 2'd2);
        sum = base + {{8{d[7]}}, d};
        if (ptr)            ea = {4'h0, 8'hFF, ofs};
        else if (sel == 1)  ea = {bk[0], sum};
        else if (sel == 2)  ea = {bk[1], sum};
        else                ea = {4'h0, base};
        en = (cmd == 2'd1) ? base + 16'd1 : base - 16'd1;
        for (int i = 0; i < 2; i++) begin
            if (we[i]) bk[i] = wd;
            else if (ptr && ps == i[0]) begin
                if (cmd == 2'd1 && base == 16'hFFFF) bk[i] = bk[i] + 4'd1;
                if (cmd == 2'd2 && base == 16'h0000) bk[i] = bk[i] - 4'd1;
            end
        end
        @(negedge clk);
        addr_sel = sel; base_val = base; disp = d; bank_wr_en = we;
        bank_wr_data = wd; ptr_cmd = cmd; ptr_sel = ps; ptr_ofs = ofs;
        @(posedge clk);
        #1;
        chk(phys_addr == ea, tag, 32'(phys_addr), 32'(ea));
        chk(idx_next_vld == ptr, tag, 32'(idx_next_vld), 32'(ptr));
        if (ptr) chk(idx_next == en, tag, 32'(idx_next), 32'(en));
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] bases [4];
        logic [7:0]  disps [5];
        bases = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0050};
        disps = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01};
        bk[0] = 4'h0; bk[1] = 4'h0;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk(phys_addr == 20'h0, "R1 addr", 32'(phys_addr), 32'h0);
        chk(idx_next_vld == 1'b0, "R1 vld", 32'(idx_next_vld), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'd1, 16'h1234, 8'h00, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R1 bank0 zero");
        step(2'd2, 16'h4321, 8'h00, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R1 bank1 zero");

        // R2 / R4: sweep every bank value on both banks
        for (int b = 0; b < 16; b++) begin
            for (int i = 0; i < 2; i++) begin
                step(2'd0, 16'h0000, 8'h00, 2'(1 << i), 4'(b), 2'd0, 1'b0, 8'h00, "R4 write");
                for (int x = 0; x < 4; x++)
                    for (int y = 0; y < 5; y++)
                        step(2'(i + 1), bases[x], disps[y], 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R2 index addr");
                step(2'(2 - i), 16'hABCD, 8'h10, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R4 other bank");
            end
        end

        // R3: direct references ignore banks and displacement
        step(2'd1, 16'h0000, 8'h00, 2'b11, 4'h9, 2'd0, 1'b0, 8'h00, "R4 both");
        step(2'd0, 16'hFEDC, 8'h55, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R3 sel0");
        step(2'd3, 16'h0123, 8'hAA, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R3 sel3");

        // R5 / R7: step-up
        step(2'd0, 16'h0, 8'h0, 2'b11, 4'h3, 2'd0, 1'b0, 8'h00, "R4 preset");
        step(2'd1, 16'h1000, 8'h0, 2'b00, 4'h0, 2'd1, 1'b0, 8'h22, "R5 inc plain");
        step(2'd1, 16'h0000, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R7 no carry");
        step(2'd2, 16'hFFFF, 8'h0, 2'b00, 4'h0, 2'd1, 1'b0, 8'h33, "R5 inc wrap");
        step(2'd1, 16'h0010, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R5 bank carried");
        step(2'd2, 16'h0010, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R7 other bank");
        step(2'd0, 16'h0, 8'h0, 2'b10, 4'hF, 2'd0, 1'b0, 8'h00, "R4 bank1=F");
        step(2'd0, 16'hFFFF, 8'h0, 2'b00, 4'h0, 2'd1, 1'b1, 8'h44, "R5 inc wrap16");
        step(2'd2, 16'h0020, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R5 bank mod16");

        // R6: step-down
        step(2'd1, 16'h0000, 8'h0, 2'b00, 4'h0, 2'd2, 1'b0, 8'h55, "R6 dec wrap");
        step(2'd1, 16'h0030, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R6 bank borrowed");
        step(2'd2, 16'h0000, 8'h0, 2'b00, 4'h0, 2'd2, 1'b1, 8'h66, "R6 dec wrap16");
        step(2'd2, 16'h0040, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R6 bank mod16");
        step(2'd1, 16'h0001, 8'h0, 2'b00, 4'h0, 2'd2, 1'b0, 8'h77, "R7 dec plain");
        step(2'd1, 16'h0050, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R7 no borrow");

        // R8: reserved command code and page address
        step(2'd1, 16'h2222, 8'h01, 2'b00, 4'h0, 2'd3, 1'b0, 8'h88, "R8 rsv cmd");
        for (int v = 0; v < 4; v++)
            for (int c = 1; c < 3; c++)
                for (int p = 0; p < 2; p++) begin
                    step(2'(v), bases[v], 8'h0, 2'b00, 4'h0, 2'(c), 1'(p), 8'(v * 37 + c), "R8 page");
                    step(2'(p + 1), 16'h0100, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R5 R6 follow");
                end

        // R9: write beats carry on same bank; other bank written alongside
        step(2'd0, 16'hFFFF, 8'h0, 2'b01, 4'h9, 2'd1, 1'b0, 8'h01, "R9 write wins");
        step(2'd1, 16'h0060, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R9 check");
        step(2'd0, 16'hFFFF, 8'h0, 2'b10, 4'h5, 2'd1, 1'b0, 8'h02, "R9 cross");
        step(2'd1, 16'h0070, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R9 carried");
        step(2'd2, 16'h0070, 8'h0, 2'b00, 4'h0, 2'd0, 1'b0, 8'h00, "R9 written");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule